// File: doc/BRIEF.md
# Operate Instruction Execution Unit

This unit carries out the three data-manipulating instructions of a small 16-bit load/store processor: two's-complement addition, bitwise AND and bitwise complement. Each cycle it takes one 16-bit instruction word and decodes it. It reads up to two operands from an internal file of eight 16-bit registers. The second operand of ADD and AND is either a register or a sign-extended 5-bit literal. The unit then writes the result back to the named destination register at the next rising clock edge.

Alongside the register file, the unit holds a three-bit condition-code register. Exactly one of its negative, zero and positive flags is set at any time. Every operate result refreshes these flags. A separate load input lets the rest of the processor set the flags from any 16-bit value, for example a value just loaded from memory. Instruction words carrying any other opcode pass through without effect.

Top module: `opx_unit`

## Requirements
- R1: After reset the condition code reads 3'b010 (zero) and every register holds 0.
- R2: Opcode 4'b0001 with bit 5 at 0 writes reg[bits 8:6] + reg[bits 2:0] (modulo 2^16) to reg[bits 11:9]. Bits 4:3 are ignored.
- R3: Opcode 4'b0001 with bit 5 at 1 adds reg[bits 8:6] to bits 4:0 sign-extended to 16 bits.
- R4: Opcode 4'b0101 writes the bitwise AND of reg[bits 8:6] and the second operand, which is selected by bit 5 exactly as in R2 and R3.
- R5: Opcode 4'b1001 writes the bitwise complement of reg[bits 8:6]; bits 5:0 are ignored.
- R6: For the three operate opcodes, wr_en_o is 1 in the same cycle, with wr_addr_o = bits 11:9 and wr_data_o = the result. The register changes at the rising edge, and the next instruction sees the new value. A source read in the same cycle as a write to that register returns the old value.
- R7: At the edge that ends an operate cycle, the condition code becomes 3'b100 (N, bit 2) if result bit 15 is 1, 3'b010 (Z, bit 1) if the result is 0, and 3'b001 (P, bit 0) otherwise.
- R8: The condition code always has exactly one bit set.
- R9: Any other opcode gives wr_en_o = 0 and leaves all registers unchanged. It also leaves the condition code unchanged unless cc_load_i is asserted.
- R10: With cc_load_i at 1 in a non-operate cycle, the condition code takes the N/Z/P classification of cc_value_i at the next edge.
- R11: If cc_load_i is 1 in the same cycle as an operate instruction, the operate result sets the condition code and cc_value_i is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word for this cycle |
| cc_load_i | input | 1 | Request to set flags from cc_value_i |
| cc_value_i | input | 16 | Value classified when cc_load_i is set |
| wr_en_o | output | 1 | Register write happening this cycle |
| wr_addr_o | output | 3 | Destination register index |
| wr_data_o | output | 16 | Result being written |
| cc_o | output | 3 | Condition code {N, Z, P} |

## Verification
The bench builds the unit with its default 16-bit width and eight registers. At these values every register index, both operand modes and the full 5-bit literal range are reachable in one run. Repeated self-addition drives a register to 16'h8000. Its complement 16'h7FFF, plus one, then wraps into the negative range, which exercises the sign boundary for both the result and the flags. Random instruction mixes, including unused opcodes and loads that collide with operate cycles, are compared every cycle against a behavioural model.

// File: rtl/opx_unit.sv
`timescale 1ns/1ps
module opx_unit #(
  parameter int XLEN = 16,
  parameter int NREG = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] instr_i,
  input  logic        cc_load_i,
  input  logic [15:0] cc_value_i,
  output logic        wr_en_o,
  output logic [2:0]  wr_addr_o,
  output logic [15:0] wr_data_o,
  output logic [2:0]  cc_o
);
  localparam int AW  = $clog2(NREG);
  localparam int IMW = 5;

  logic [XLEN-1:0] rf [NREG];
  logic [2:0]      cc_q;

  wire [3:0]    opc   = instr_i[15:12];
  wire          do_add = (opc == 4'b0001);
  wire          do_and = (opc == 4'b0101);
  wire          do_not = (opc == 4'b1001);
  wire [AW-1:0] dst   = instr_i[11:9];
  wire [AW-1:0] src1  = instr_i[8:6];
  wire [AW-1:0] src2  = instr_i[2:0];

  wire [XLEN-1:0] imm  = {{(XLEN-IMW){instr_i[IMW-1]}}, instr_i[IMW-1:0]};
  wire [XLEN-1:0] opa  = rf[src1];
  wire [XLEN-1:0] opb  = instr_i[5] ? imm : rf[src2];

  logic [XLEN-1:0] res;
  always_comb begin
    res = '0;
    if (do_add)      res = opa + opb;
    else if (do_and) res = opa & opb;
    else if (do_not) res = ~opa;
  end

  function automatic logic [2:0] classify(input logic [XLEN-1:0] v);
    if (v[XLEN-1])   return 3'b100;
    else if (v == 0) return 3'b010;
    else             return 3'b001;
  endfunction

  assign wr_en_o   = do_add | do_and | do_not;
  assign wr_addr_o = dst;
  assign wr_data_o = res;
  assign cc_o      = cc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_q <= 3'b010;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wr_en_o) begin
      rf[dst] <= res;
      cc_q    <= classify(res);
    end else if (cc_load_i) begin
      cc_q    <= classify(cc_value_i);
    end
  end
endmodule

module opx_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] instr_i,
  input logic        cc_load_i,
  input logic [15:0] cc_value_i,
  input logic        wr_en_o,
  input logic [2:0]  wr_addr_o,
  input logic [15:0] wr_data_o,
  input logic [2:0]  cc_o
);
  wire is_op = (instr_i[15:12] == 4'b0001) || (instr_i[15:12] == 4'b0101) ||
               (instr_i[15:12] == 4'b1001);

  p_cc_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc_o) == 1);

  p_dest_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> wr_addr_o == instr_i[11:9]);

  p_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_op |-> !wr_en_o);

  p_cc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_o && !cc_load_i) |=> $stable(cc_o));

  p_cc_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> cc_o == ($past(wr_data_o[15]) ? 3'b100 :
                         ($past(wr_data_o) == 16'h0) ? 3'b010 : 3'b001));

  p_cc_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_load_i && !wr_en_o) |=> cc_o == ($past(cc_value_i[15]) ? 3'b100 :
                                ($past(cc_value_i) == 16'h0) ? 3'b010 : 3'b001));
endmodule

bind opx_unit opx_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .cc_load_i(cc_load_i),
  .cc_value_i(cc_value_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
  .wr_data_o(wr_data_o), .cc_o(cc_o)
);

// File: tb/sim_opx_unit.sv
`timescale 1ns/1ps
module sim_opx_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] instr = 16'h0000;
  logic        ccl = 0;
  logic [15:0] ccv = 16'h0000;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  cc;

  always #5 clk = ~clk;

  opx_unit u0 (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .cc_load_i(ccl),
    .cc_value_i(ccv), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .cc_o(cc)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] mreg [8];
  logic [2:0]  mcc;

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] nzp(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  function automatic logic [15:0] rr(input logic [3:0] op, input int d, input int a, input int b);
    return {op, 3'(d), 3'(a), 3'b000, 3'(b)};
  endfunction
  function automatic logic [15:0] ri(input logic [3:0] op, input int d, input int a, input int k);
    return {op, 3'(d), 3'(a), 1'b1, 5'(k)};
  endfunction
  function automatic logic [15:0] nt(input int d, input int a);
    return {4'b1001, 3'(d), 3'(a), 6'b111111};
  endfunction

  task automatic step(input logic [15:0] ins, input logic ld, input logic [15:0] lv, input string force_tag);
    logic [3:0]  op;
    logic [15:0] b, r;
    logic        isop;
    string       tag;
    @(negedge clk);
    instr = ins; ccl = ld; ccv = lv;
    #2;
    op = ins[15:12];
    b = ins[5] ? {{11{ins[4]}}, ins[4:0]} : mreg[ins[2:0]];
    isop = 1'b1;
    case (op)
      4'b0001: begin r = mreg[ins[8:6]] + b; tag = ins[5] ? "R3" : "R2"; end
      4'b0101: begin r = mreg[ins[8:6]] & b; tag = "R4"; end
      4'b1001: begin r = ~mreg[ins[8:6]];    tag = "R5"; end
      default: begin r = 16'h0; isop = 1'b0; tag = "R9"; end
    endcase
    if (force_tag != "") tag = force_tag;
    check("R8", "cc onehot", 16'($countones(cc) == 1), 16'h1);
    check(tag, "cc before edge", {13'h0, cc}, {13'h0, mcc});
    check(isop ? "R6" : "R9", "wr_en", {15'h0, wr_en}, {15'h0, isop});
    if (isop) begin
      check("R6", "wr_addr", {13'h0, wr_addr}, {13'h0, ins[11:9]});
      check(tag, "wr_data", wr_data, r);
      mreg[ins[11:9]] = r;
      mcc = nzp(r);
    end else if (ld) begin
      mcc = nzp(lv);
    end
    @(posedge clk);
  endtask

  initial begin
    #(10 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = 16'h0;
    mcc = 3'b010;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1 check("R1", "cc after reset", {13'h0, cc}, 16'h0002);
    for (int i = 0; i < 8; i++) step(ri(4'b0001, i, i, 0), 1'b0, 16'h0, "R1");
    // R3: literal boundaries
    step(ri(4'b0001, 1, 0, -1), 1'b0, 16'h0, "R3");
    step(ri(4'b0001, 2, 0, 15), 1'b0, 16'h0, "R3");
    step(ri(4'b0001, 3, 0, -16), 1'b0, 16'h0, "R3");
    // R2: register add, bits 4:3 set but ignored
    step(rr(4'b0001, 4, 2, 3) | 16'h0018, 1'b0, 16'h0, "R2");
    // R6: self-doubling, each reads the value just written
    for (int i = 0; i < 15; i++) step(rr(4'b0001, 1, 1, 1), 1'b0, 16'h0, "R6");
    step(nt(5, 1), 1'b0, 16'h0, "R5");
    step(ri(4'b0001, 6, 5, 1), 1'b0, 16'h0, "R7");
    step(rr(4'b0101, 7, 5, 6), 1'b0, 16'h0, "R4");
    step(ri(4'b0101, 7, 5, 12), 1'b0, 16'h0, "R4");
    step({4'b1001, 3'd2, 3'd2, 6'b000000}, 1'b0, 16'h0, "R5");
    // R10 / R11
    step(16'h2000, 1'b1, 16'h8001, "R10");
    step(16'h3000, 1'b1, 16'h0000, "R10");
    step(16'hF000, 1'b1, 16'h0042, "R10");
    step(ri(4'b0101, 0, 0, 0), 1'b1, 16'h8000, "R11");
    step(ri(4'b0001, 0, 0, 3), 1'b1, 16'hFFFF, "R11");
    // R9: unused opcodes with all fields populated
    for (int o = 0; o < 16; o++)
      if (o != 1 && o != 5 && o != 9) step({4'(o), 12'hFFF}, 1'b0, 16'h0, "R9");
    for (int i = 0; i < 8; i++) step(ri(4'b0001, i, i, 0), 1'b0, 16'h0, "R9");
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [15:0] w;
      int sel;
      w = 16'($urandom);
      sel = $urandom_range(0, 3);
      if (sel == 0) w[15:12] = 4'b0001;
      else if (sel == 1) w[15:12] = 4'b0101;
      else if (sel == 2) w[15:12] = 4'b1001;
      step(w, ($urandom_range(0, 3) == 0), 16'($urandom), "");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule